// File: doc/BRIEF.md
# Segmented Paged Address Translator

This block turns a 32-bit effective address into a 19-bit physical address in two steps. The top four address bits pick one of sixteen segment registers. Each segment register holds an 8-bit page base. That base is added, modulo 256, to the 8-bit page index taken from address bits 18:11, which gives a linear page number. The linear page number and a 4-bit address-space identifier then select one byte in a page map. The map holds sixteen independent address spaces of 256 entries each, all in one synchronous RAM. That byte is the physical page number. The 11-bit offset inside the 2 kB page passes straight through.

A management port lets the operating system write and read back segment registers and map entries. Map entries are addressed by map number and virtual page index. A small controller has two states. CLEAR is entered on reset. In CLEAR the controller walks every map entry and writes zero, and requests on both ports are ignored. The transition CLEAR to READY is taken when the last entry has been written. READY holds until the next reset, and there the block serves both ports. After start-up every page therefore maps to physical page 0, so only 2 kB is usable until software fills the maps.

Top module: `spt_translator`

## Requirements
- R1: While reset is held, `rdy`, `tr_out_valid` and `mg_rvalid` are 0. After reset the block passes through CLEAR to READY and raises `rdy`. It then stays in READY. At that point every segment register and every map entry reads zero, so any translation yields physical page 0.
- R2: A translation request accepted in a cycle (`tr_valid` high with `rdy` high) gives `tr_out_valid` high in the next cycle only. With no accepted request, `tr_out_valid` is low.
- R3: `tr_paddr[10:0]` equals bits 10:0 of the address of the request that was accepted.
- R4: The segment register is selected by address bits 31:28. The linear page is (segment base + address bits 18:11) modulo 256. Address bits 27:19 have no effect on the result.
- R5: `tr_paddr[18:11]` is the map entry at (`tr_asid`, linear page). Each of the 16 maps is independent: a write to one map does not change what another map returns.
- R6: Command 0 writes `mg_wdata` into segment register `mg_index[3:0]`. Command 1 returns that register on `mg_rdata` in the next cycle, with `mg_rvalid` high.
- R7: Command 2 writes `mg_wdata` into map entry (`mg_map_id`, `mg_index`). Command 3 returns that entry on `mg_rdata` in the next cycle, with `mg_rvalid` high. `mg_rvalid` is high only in the cycle after an accepted read command.
- R8: A map write takes effect for translations issued in the following cycle. A translation issued in the same cycle as the write sees the old entry.
- R9: While `rdy` is low, translation and management requests are ignored. No output valid is raised, and no segment or map write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rdy | output | 1 | High once the map clear is complete |
| tr_valid | input | 1 | Translation request strobe |
| tr_addr | input | 32 | Effective address to translate |
| tr_asid | input | 4 | Address-space (map) selector for the request |
| tr_out_valid | output | 1 | Translation result valid |
| tr_paddr | output | 19 | Physical address result |
| mg_valid | input | 1 | Management command strobe |
| mg_cmd | input | 2 | 0 segment write, 1 segment read, 2 map write, 3 map read |
| mg_map_id | input | 4 | Map number for map commands |
| mg_index | input | 8 | Virtual page index, or segment number in bits 3:0 |
| mg_wdata | input | 8 | Segment base or physical page to write |
| mg_rvalid | output | 1 | Read data valid |
| mg_rdata | output | 8 | Read data |

## Verification
The assertions check the timing on every cycle. They check the one-cycle valid pipeline of both ports, that the offset passes through, that outputs stay quiet while the block is not ready, and that READY, once reached, is never left. The arithmetic of the translation can only be shown by the bench scenarios, which compare results against their own model of the segment registers and maps. Those are the base-plus-index wrap at 256, the choice of map by address-space number, and the isolation between maps. The scenarios also cover the ordering when a write and a translation share a cycle, and that writes issued during the clear are lost.

// File: rtl/spt_pkg.sv
package spt_pkg;

    typedef enum logic [1:0] {
        CMD_SEG_WR = 2'd0,
        CMD_SEG_RD = 2'd1,
        CMD_MAP_WR = 2'd2,
        CMD_MAP_RD = 2'd3
    } mg_cmd_e;

    typedef enum logic {
        ST_CLEAR = 1'b0,
        ST_READY = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/spt_ctrl.sv
module spt_ctrl
    import spt_pkg::*;
#(
    parameter int DEPTH = 4096,
    parameter int IDX_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             rdy,
    output logic             clr_we,
    output logic [IDX_W-1:0] clr_addr
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    ctl_state_e       state_q;
    ctl_state_e       state_d;
    logic [IDX_W-1:0] idx_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    // sweep counter for the clear walk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (state_q == ST_CLEAR) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: if (idx_q == LAST_IDX) state_d = ST_READY;
            ST_READY: state_d = ST_READY;
            default:  state_d = ST_CLEAR;
        endcase
    end

    // outputs
    always_comb begin
        rdy      = 1'b0;
        clr_we   = 1'b0;
        clr_addr = idx_q;
        unique case (state_q)
            ST_CLEAR: clr_we = 1'b1;
            ST_READY: rdy    = 1'b1;
            default:  rdy    = 1'b0;
        endcase
    end

endmodule

// File: rtl/spt_seg_file.sv
module spt_seg_file #(
    parameter int SEG_BITS = 4,
    parameter int BASE_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [SEG_BITS-1:0] waddr,
    input  logic [BASE_W-1:0]   wdata,
    input  logic [SEG_BITS-1:0] sel_tr,
    output logic [BASE_W-1:0]   base_tr,
    input  logic [SEG_BITS-1:0] sel_mg,
    output logic [BASE_W-1:0]   base_mg
);

    localparam int N_SEG = 1 << SEG_BITS;

    logic [BASE_W-1:0] seg_q [N_SEG];

    for (genvar g = 0; g < N_SEG; g++) begin : g_seg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seg_q[g] <= '0;
            end else if (we && (waddr == SEG_BITS'(g))) begin
                seg_q[g] <= wdata;
            end
        end
    end

    assign base_tr = seg_q[sel_tr];
    assign base_mg = seg_q[sel_mg];

endmodule

// File: rtl/spt_map_ram.sv
module spt_map_ram #(
    parameter int AW = 12,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] ra_a,
    output logic [DW-1:0] q_a,
    input  logic [AW-1:0] ra_b,
    output logic [DW-1:0] q_b
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // registered reads return the value held before a same-edge write
    always_ff @(posedge clk) begin
        q_a <= mem[ra_a];
        q_b <= mem[ra_b];
    end

endmodule

// File: rtl/spt_translator.sv
module spt_translator
    import spt_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int SEG_BITS  = 4,
    parameter int PAGE_BITS = 11,
    parameter int VPI_W     = 8,
    parameter int PPN_W     = 8,
    parameter int MAP_ID_W  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    output logic                          rdy,
    input  logic                          tr_valid,
    input  logic [ADDR_W-1:0]             tr_addr,
    input  logic [MAP_ID_W-1:0]           tr_asid,
    output logic                          tr_out_valid,
    output logic [PPN_W+PAGE_BITS-1:0]    tr_paddr,
    input  logic                          mg_valid,
    input  logic [1:0]                    mg_cmd,
    input  logic [MAP_ID_W-1:0]           mg_map_id,
    input  logic [VPI_W-1:0]              mg_index,
    input  logic [PPN_W-1:0]              mg_wdata,
    output logic                          mg_rvalid,
    output logic [PPN_W-1:0]              mg_rdata
);

    localparam int N_MAPS = 1 << MAP_ID_W;
    localparam int N_VP   = 1 << VPI_W;
    localparam int DEPTH  = N_MAPS * N_VP;
    localparam int IDX_W  = MAP_ID_W + VPI_W;
    localparam int PA_W   = PPN_W + PAGE_BITS;

    mg_cmd_e cmd;
    assign cmd = mg_cmd_e'(mg_cmd);

    logic             clr_we;
    logic [IDX_W-1:0] clr_addr;

    spt_ctrl #(
        .DEPTH (DEPTH),
        .IDX_W (IDX_W)
    ) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .rdy      (rdy),
        .clr_we   (clr_we),
        .clr_addr (clr_addr)
    );

    logic tr_fire;
    logic mg_fire;
    assign tr_fire = tr_valid && rdy;
    assign mg_fire = mg_valid && rdy;

    // segmentation stage
    logic [SEG_BITS-1:0] seg_sel;
    logic [VPI_W-1:0]    vpi;
    logic [VPI_W-1:0]    seg_base_tr;
    logic [VPI_W-1:0]    seg_base_mg;
    logic [VPI_W-1:0]    lin_page;

    assign seg_sel  = tr_addr[ADDR_W-1 -: SEG_BITS];
    assign vpi      = tr_addr[PAGE_BITS +: VPI_W];
    assign lin_page = seg_base_tr + vpi;

    spt_seg_file #(
        .SEG_BITS (SEG_BITS),
        .BASE_W   (VPI_W)
    ) i_segs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (mg_fire && (cmd == CMD_SEG_WR)),
        .waddr   (mg_index[SEG_BITS-1:0]),
        .wdata   (mg_wdata[VPI_W-1:0]),
        .sel_tr  (seg_sel),
        .base_tr (seg_base_tr),
        .sel_mg  (mg_index[SEG_BITS-1:0]),
        .base_mg (seg_base_mg)
    );

    // map storage: one write port shared by the clear walk and management
    logic             ram_we;
    logic [IDX_W-1:0] ram_waddr;
    logic [PPN_W-1:0] ram_wdata;
    logic [PPN_W-1:0] ram_qa;
    logic [PPN_W-1:0] ram_qb;

    always_comb begin
        ram_we    = 1'b0;
        ram_waddr = {mg_map_id, mg_index};
        ram_wdata = mg_wdata;
        if (clr_we) begin
            ram_we    = 1'b1;
            ram_waddr = clr_addr;
            ram_wdata = '0;
        end else if (mg_fire && (cmd == CMD_MAP_WR)) begin
            ram_we = 1'b1;
        end
    end

    spt_map_ram #(
        .AW (IDX_W),
        .DW (PPN_W)
    ) i_map (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .ra_a  ({tr_asid, lin_page}),
        .q_a   (ram_qa),
        .ra_b  ({mg_map_id, mg_index}),
        .q_b   (ram_qb)
    );

    // pipeline registers alongside the RAM read
    logic [PAGE_BITS-1:0] off_q;
    logic                 tr_v_q;
    logic                 rd_v_q;
    logic                 rd_seg_q;
    logic [PPN_W-1:0]     seg_rd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tr_v_q   <= 1'b0;
            rd_v_q   <= 1'b0;
            rd_seg_q <= 1'b0;
            off_q    <= '0;
            seg_rd_q <= '0;
        end else begin
            tr_v_q <= tr_fire;
            rd_v_q <= mg_fire && ((cmd == CMD_SEG_RD) || (cmd == CMD_MAP_RD));
            if (tr_fire) begin
                off_q <= tr_addr[PAGE_BITS-1:0];
            end
            if (mg_fire) begin
                rd_seg_q <= (cmd == CMD_SEG_RD);
                seg_rd_q <= PPN_W'(seg_base_mg);
            end
        end
    end

    assign tr_out_valid = tr_v_q;
    assign tr_paddr     = {ram_qa, off_q};
    assign mg_rvalid    = rd_v_q;
    assign mg_rdata     = rd_seg_q ? seg_rd_q : ram_qb;

endmodule

// File: rtl/spt_checker.sv
module spt_checker #(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 11,
    parameter int PA_W      = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rdy,
    input logic              tr_valid,
    input logic [ADDR_W-1:0] tr_addr,
    input logic              tr_out_valid,
    input logic [PA_W-1:0]   tr_paddr,
    input logic              mg_valid,
    input logic [1:0]        mg_cmd,
    input logic              mg_rvalid
);

    logic mg_read;
    assign mg_read = mg_valid && rdy && ((mg_cmd == 2'd1) || (mg_cmd == 2'd3));

    AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |=> rdy); // R1

    AST_TR_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (tr_valid && rdy) |=> tr_out_valid); // R2

    AST_TR_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(tr_valid && rdy) |=> !tr_out_valid); // R2

    AST_OFFSET_THRU: assert property (@(posedge clk) disable iff (!rst_n)
        tr_out_valid |-> (tr_paddr[PAGE_BITS-1:0] == $past(tr_addr[PAGE_BITS-1:0]))); // R3

    AST_RD_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        mg_read |=> mg_rvalid); // R7

    AST_RD_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !mg_read |=> !mg_rvalid); // R7

    AST_QUIET_UNREADY: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy |=> (!tr_out_valid && !mg_rvalid)); // R9

endmodule

bind spt_translator spt_checker #(
    .ADDR_W    (ADDR_W),
    .PAGE_BITS (PAGE_BITS),
    .PA_W      (PPN_W + PAGE_BITS)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rdy          (rdy),
    .tr_valid     (tr_valid),
    .tr_addr      (tr_addr),
    .tr_out_valid (tr_out_valid),
    .tr_paddr     (tr_paddr),
    .mg_valid     (mg_valid),
    .mg_cmd       (mg_cmd),
    .mg_rvalid    (mg_rvalid)
);

// File: tb/test_spt_translator.sv
module test_spt_translator;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rdy;
    logic        tr_valid = 1'b0;
    logic [31:0] tr_addr = '0;
    logic [3:0]  tr_asid = '0;
    logic        tr_out_valid;
    logic [18:0] tr_paddr;
    logic        mg_valid = 1'b0;
    logic [1:0]  mg_cmd = '0;
    logic [3:0]  mg_map_id = '0;
    logic [7:0]  mg_index = '0;
    logic [7:0]  mg_wdata = '0;
    logic        mg_rvalid;
    logic [7:0]  mg_rdata;

    int tests = 0;
    int fails = 0;

    logic [7:0] m_seg [16];
    logic [7:0] m_map [16][256];

    always #(CLK_PERIOD/2) clk = ~clk;

    spt_translator i_spt_translator (
        .clk          (clk),
        .rst_n        (rst_n),
        .rdy          (rdy),
        .tr_valid     (tr_valid),
        .tr_addr      (tr_addr),
        .tr_asid      (tr_asid),
        .tr_out_valid (tr_out_valid),
        .tr_paddr     (tr_paddr),
        .mg_valid     (mg_valid),
        .mg_cmd       (mg_cmd),
        .mg_map_id    (mg_map_id),
        .mg_index     (mg_index),
        .mg_wdata     (mg_wdata),
        .mg_rvalid    (mg_rvalid),
        .mg_rdata     (mg_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [18:0] model_pa(input logic [31:0] a, input logic [3:0] asid);
        logic [7:0] lp;
        lp = m_seg[a[31:28]] + a[18:11];
        return {m_map[asid][lp], a[10:0]};
    endfunction

    task automatic model_clear();
        for (int s = 0; s < 16; s++) m_seg[s] = '0;
        for (int m = 0; m < 16; m++)
            for (int p = 0; p < 256; p++) m_map[m][p] = '0;
    endtask

    task automatic translate(input logic [31:0] a, input logic [3:0] asid,
                             output logic ov, output logic [18:0] pa);
        @(negedge clk);
        tr_valid = 1'b1; tr_addr = a; tr_asid = asid;
        @(negedge clk);
        tr_valid = 1'b0;
        ov = tr_out_valid; pa = tr_paddr;
    endtask

    task automatic mg_write(input logic [1:0] c, input logic [3:0] id,
                            input logic [7:0] idx, input logic [7:0] d);
        @(negedge clk);
        mg_valid = 1'b1; mg_cmd = c; mg_map_id = id; mg_index = idx; mg_wdata = d;
        @(negedge clk);
        mg_valid = 1'b0;
        if (c == 2'd0) m_seg[idx[3:0]] = d;
        if (c == 2'd2) m_map[id][idx] = d;
    endtask

    task automatic mg_read(input logic [1:0] c, input logic [3:0] id,
                           input logic [7:0] idx, output logic rv, output logic [7:0] d);
        @(negedge clk);
        mg_valid = 1'b1; mg_cmd = c; mg_map_id = id; mg_index = idx;
        @(negedge clk);
        mg_valid = 1'b0;
        rv = mg_rvalid; d = mg_rdata;
    endtask

    task automatic t_reset_and_clear();
        logic ov, rv;
        logic [18:0] pa;
        logic [7:0]  d;
        int wait_cnt;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 rdy in reset", {31'd0, rdy}, 32'd0);
        chk("R1 out_valid in reset", {31'd0, tr_out_valid}, 32'd0);
        chk("R1 rvalid in reset", {31'd0, mg_rvalid}, 32'd0);
        rst_n = 1'b1;
        model_clear();
        repeat (10) @(negedge clk);
        // R9: requests issued during the clear walk are dropped
        @(negedge clk);
        mg_valid = 1'b1; mg_cmd = 2'd2; mg_map_id = 4'd0; mg_index = 8'd0; mg_wdata = 8'h77;
        @(negedge clk);
        mg_cmd = 2'd0; mg_index = 8'd0; mg_wdata = 8'h05;
        @(negedge clk);
        mg_valid = 1'b0;
        translate(32'h0000_0123, 4'd0, ov, pa);
        chk("R9 no out_valid while clearing", {31'd0, ov}, 32'd0);
        mg_read(2'd3, 4'd0, 8'd0, rv, d);
        chk("R9 no rvalid while clearing", {31'd0, rv}, 32'd0);
        wait_cnt = 0;
        while (!rdy && wait_cnt < 6000) begin
            @(negedge clk);
            wait_cnt++;
        end
        chk("R1 rdy after clear", {31'd0, rdy}, 32'd1);
        mg_read(2'd1, 4'd0, 8'd0, rv, d);
        chk("R9 segment write dropped", {24'd0, d}, 32'd0);
        mg_read(2'd3, 4'd0, 8'd0, rv, d);
        chk("R9 map write dropped", {24'd0, d}, 32'd0);
    endtask

    task automatic t_zero_maps();
        logic ov;
        logic [18:0] pa;
        translate(32'hF7A3_5ABC, 4'd9, ov, pa);
        chk("R1 zero map result", {13'd0, pa}, {13'd0, 8'h00, 11'h2BC});
        chk("R2 out_valid after request", {31'd0, ov}, 32'd1);
        @(negedge clk);
        chk("R2 out_valid drops when idle", {31'd0, tr_out_valid}, 32'd0);
        translate(32'h1234_47FF, 4'd0, ov, pa);
        chk("R3 offset passes through", {21'd0, pa[10:0]}, {21'd0, 11'h7FF});
    endtask

    task automatic t_segments();
        logic rv;
        logic [7:0] d;
        mg_write(2'd0, 4'd0, 8'd3, 8'hA5);
        mg_write(2'd0, 4'd0, 8'd15, 8'h01);
        mg_read(2'd1, 4'd0, 8'd3, rv, d);
        chk("R6 segment 3 readback", {23'd0, rv, d}, {23'd0, 1'b1, 8'hA5});
        mg_read(2'd1, 4'd0, 8'd15, rv, d);
        chk("R6 segment 15 readback", {24'd0, d}, 32'h01);
        mg_read(2'd1, 4'd0, 8'd4, rv, d);
        chk("R6 untouched segment 4", {24'd0, d}, 32'h00);
        @(negedge clk);
        chk("R7 rvalid single cycle", {31'd0, mg_rvalid}, 32'd0);
    endtask

    task automatic t_maps();
        logic rv;
        logic [7:0] d;
        mg_write(2'd2, 4'd2, 8'h10, 8'h44);
        mg_write(2'd2, 4'd2, 8'h11, 8'h55);
        mg_write(2'd2, 4'd15, 8'hFF, 8'hFF);
        mg_read(2'd3, 4'd2, 8'h10, rv, d);
        chk("R7 map readback 2/10", {23'd0, rv, d}, {23'd0, 1'b1, 8'h44});
        mg_read(2'd3, 4'd2, 8'h11, rv, d);
        chk("R7 map readback 2/11", {24'd0, d}, 32'h55);
        mg_read(2'd3, 4'd15, 8'hFF, rv, d);
        chk("R7 map readback 15/FF", {24'd0, d}, 32'hFF);
        mg_read(2'd3, 4'd3, 8'h10, rv, d);
        chk("R5 other map untouched", {24'd0, d}, 32'h00);
    endtask

    task automatic t_translate();
        logic ov;
        logic [18:0] pa;
        logic [31:0] a;
        // segment 3 base A5 plus index 6B wraps to linear page 10
        a = {4'd3, 9'h1F3, 8'h6B, 11'h155};
        translate(a, 4'd2, ov, pa);
        chk("R4 base plus index wraps", {13'd0, pa}, {13'd0, 8'h44, 11'h155});
        a = {4'd3, 9'h000, 8'h6C, 11'h001};
        translate(a, 4'd2, ov, pa);
        chk("R4 next linear page", {13'd0, pa}, {13'd0, model_pa(a, 4'd2)});
        a = {4'd15, 9'h0AA, 8'hFE, 11'h3C0};
        translate(a, 4'd15, ov, pa);
        chk("R4 segment 15 to page FF", {13'd0, pa}, {13'd0, 8'hFF, 11'h3C0});
        a = {4'd3, 9'h1F3, 8'h6B, 11'h155};
        translate(a, 4'd3, ov, pa);
        chk("R5 other asid sees page 0", {13'd0, pa}, {13'd0, model_pa(a, 4'd3)});
        for (int k = 0; k < 4; k++) begin
            a = {4'd3, 9'(k * 37), 8'h6B, 11'(k * 91)};
            translate(a, 4'd2, ov, pa);
            chk("R4 bits 27:19 ignored", {13'd0, pa}, {13'd0, 8'h44, 11'(k * 91)});
        end
    endtask

    task automatic t_same_cycle();
        logic [31:0] a;
        logic [18:0] exp_old;
        logic ov;
        logic [18:0] pa;
        a = {4'd0, 9'd0, 8'h20, 11'h0AB};
        exp_old = model_pa(a, 4'd1);
        @(negedge clk);
        mg_valid = 1'b1; mg_cmd = 2'd2; mg_map_id = 4'd1; mg_index = 8'h20; mg_wdata = 8'h3C;
        tr_valid = 1'b1; tr_addr = a; tr_asid = 4'd1;
        @(negedge clk);
        mg_valid = 1'b0; tr_valid = 1'b0;
        m_map[1][8'h20] = 8'h3C;
        chk("R8 same cycle sees old entry", {13'd0, tr_paddr}, {13'd0, exp_old});
        translate(a, 4'd1, ov, pa);
        chk("R8 next cycle sees new entry", {13'd0, pa}, {13'd0, 8'h3C, 11'h0AB});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset_and_clear();
        t_zero_maps();
        t_segments();
        t_maps();
        t_translate();
        t_same_cycle();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule